// File: doc/BRIEF.md
# Analog TV Sync and Blanking Timing Generator

This block produces the raster timing for standard- and high-definition analog TV output. A pixel counter runs across each line. A second counter advances twice per line, so the vertical position is kept in half-lines. From these two positions the block derives horizontal sync, horizontal blanking and the colourburst gate, and for each field the vertical sync and equalization windows. In interlaced operation it also drives a field identifier.

Every position is a configuration input. Horizontal events are offsets counted from the start of horizontal sync and stored as the offset minus one. Vertical sync and equalization start values are kept separately for the first and second field. A progressive select stops the fields from alternating. When a field holds an odd number of half-lines, the second field starts in the middle of a line. This gives the half-line shift between interlaced fields.

Each output is registered and active high. An output reflects the counter position of the previous clock. While the enable is low, both counters are held at zero, so the raster restarts from the top of field 0 each time the enable rises.

Top module: `tvsync_timing_gen`

## Requirements
- R1: While `rst` is high or `en` is low, every output is low on the following clock. The pixel position, half-line position and field are held at 0, so the raster restarts at pixel 0 of half-line 0 in field 0 once `en` rises.
- R2: A line lasts `cfg_line_total`+1 clocks, with pixel position 0 at the start of horizontal sync. `hsync` is high for pixel positions below `cfg_hsync_len`. Every output shows the position of the previous clock.
- R3: `hblank` is high for pixel positions at or above `cfg_hblank_start`+1, and for positions below `cfg_hblank_end`+1. The blanking interval therefore wraps across the line boundary.
- R4: When `cfg_burst_en` is 1, `burst` is high for pixel positions from `cfg_burst_start`+1 up to, but not including, `cfg_burst_start`+1+`cfg_burst_len`. When `cfg_burst_en` is 0, `burst` stays low.
- R5: The half-line position advances at pixel position `cfg_line_total` and at pixel position ((`cfg_line_total`+1)>>1)-1. It wraps to 0 after reaching `cfg_field_len`, so a field holds `cfg_field_len`+1 half-lines.
- R6: `vsync` is high for half-line positions from S+1 up to, but not including, S+1+`cfg_vsync_len`. S is `cfg_vsync_start_f1` in field 0 and `cfg_vsync_start_f2` in field 1.
- R7: When `cfg_eq_en` is 1, `veq` is high for half-line positions from E+1 up to, but not including, E+1+`cfg_eq_len`. E is `cfg_eq_start_f1` in field 0 and `cfg_eq_start_f2` in field 1. When `cfg_eq_en` is 0, `veq` stays low.
- R8: When `cfg_progressive` is 0, the field flips at the end of every field and `field_id` shows it (0 for the first field, 1 for the second). When `cfg_progressive` is 1, the field stays 0, `field_id` stays low and only the first-field start values are used.
- R9: When a field holds an odd number of half-lines, consecutive `field_id` changes are (`cfg_field_len`+1) half-lines apart. The second field therefore begins at mid-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds counters at zero |
| cfg_line_total | input | HW | Pixels per line minus one |
| cfg_hsync_len | input | HW | Horizontal sync width in pixels |
| cfg_hblank_start | input | HW | Blank start, offset from sync start minus one |
| cfg_hblank_end | input | HW | Blank end, offset from sync start minus one |
| cfg_burst_en | input | 1 | Burst gate enable |
| cfg_burst_start | input | HW | Burst start, offset from sync start minus one |
| cfg_burst_len | input | HW | Burst width in pixels |
| cfg_progressive | input | 1 | 1 selects progressive scan |
| cfg_field_len | input | VW | Half-lines per field minus one |
| cfg_vsync_len | input | VW | Vertical sync width in half-lines |
| cfg_vsync_start_f1 | input | SW | First-field vsync start minus one, in half-lines |
| cfg_vsync_start_f2 | input | SW | Second-field vsync start minus one, in half-lines |
| cfg_eq_en | input | 1 | Equalization enable |
| cfg_eq_len | input | SW | Equalization width in half-lines |
| cfg_eq_start_f1 | input | SW | First-field equalization start minus one |
| cfg_eq_start_f2 | input | SW | Second-field equalization start minus one |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| burst | output | 1 | Colourburst gate |
| vsync | output | 1 | Vertical sync |
| veq | output | 1 | Equalization window |
| field_id | output | 1 | Current field (0 or 1) |

## Verification
The bench builds the block with its default widths: 13-bit pixel positions, 11-bit half-line positions and 7-bit start offsets. Short lines of 2 to 20 pixels make whole fields, field alternation and odd-length fields happen within a few hundred clocks, while every compare still runs at full width. Both even and odd line totals are used, so the mid-line half-line tick falls on either side of an exact split. A one-pixel sync on a two-pixel line makes the two half-line ticks nearly coincide.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int DEF_HW = 13;
  localparam int DEF_VW = 11;
  localparam int DEF_SW = 7;

  typedef struct packed {
    logic hsync;
    logic hblank;
    logic burst;
  } h_out_t;

  typedef struct packed {
    logic vsync;
    logic veq;
    logic field;
  } v_out_t;
endpackage

// File: rtl/tvs_hcount.sv
module tvs_hcount
  import tvs_pkg::*;
#(
  parameter int HW = DEF_HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [HW-1:0] cfg_line_total,
  input  logic [HW-1:0] cfg_hsync_len,
  input  logic [HW-1:0] cfg_hblank_start,
  input  logic [HW-1:0] cfg_hblank_end,
  input  logic          cfg_burst_en,
  input  logic [HW-1:0] cfg_burst_start,
  input  logic [HW-1:0] cfg_burst_len,
  output logic          half_tick,
  output h_out_t        hout
);
  // Compare width: room for offset+1+length without wrap.
  localparam int CW = HW + 2;

  logic [HW-1:0] px;
  logic [CW-1:0] pos, lt, mid, hbs, hbe, bs, be;

  always_comb begin
    pos = CW'(px);
    lt  = CW'(cfg_line_total);
    mid = ((lt + CW'(1)) >> 1) - CW'(1);  // all ones when line is 1 px: never matches
    hbs = CW'(cfg_hblank_start) + CW'(1);
    hbe = CW'(cfg_hblank_end) + CW'(1);
    bs  = CW'(cfg_burst_start) + CW'(1);
    be  = bs + CW'(cfg_burst_len);
    half_tick = en && ((pos == lt) || (pos == mid));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      px   <= '0;
      hout <= '0;
    end else begin
      px          <= (pos >= lt) ? '0 : px + HW'(1);
      hout.hsync  <= pos < CW'(cfg_hsync_len);
      hout.hblank <= (pos >= hbs) || (pos < hbe);
      hout.burst  <= cfg_burst_en && (pos >= bs) && (pos < be);
    end
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && px == cfg_line_total) |=> (px == '0)) else $error("line wrap"); // R2
  AST_HSYNC_LEAD: assert property (@(posedge clk) disable iff (rst)
    (en && px == '0 && cfg_hsync_len != '0) |=> hout.hsync) else $error("hsync lead"); // R2
  AST_BURST_GATE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_burst_en) |=> !hout.burst) else $error("burst gate"); // R4
endmodule

// File: rtl/tvs_vcount.sv
module tvs_vcount
  import tvs_pkg::*;
#(
  parameter int VW = DEF_VW,
  parameter int SW = DEF_SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          half_tick,
  input  logic          cfg_progressive,
  input  logic [VW-1:0] cfg_field_len,
  input  logic [VW-1:0] cfg_vsync_len,
  input  logic [SW-1:0] cfg_vsync_start_f1,
  input  logic [SW-1:0] cfg_vsync_start_f2,
  input  logic          cfg_eq_en,
  input  logic [SW-1:0] cfg_eq_len,
  input  logic [SW-1:0] cfg_eq_start_f1,
  input  logic [SW-1:0] cfg_eq_start_f2,
  output v_out_t        vout
);
  localparam int CW = ((VW > SW) ? VW : SW) + 2;

  logic [VW-1:0] hl;
  logic          fld;
  logic [CW-1:0] pos, vs, ve, es, ee;

  always_comb begin
    pos = CW'(hl);
    vs  = CW'(fld ? cfg_vsync_start_f2 : cfg_vsync_start_f1) + CW'(1);
    ve  = vs + CW'(cfg_vsync_len);
    es  = CW'(fld ? cfg_eq_start_f2 : cfg_eq_start_f1) + CW'(1);
    ee  = es + CW'(cfg_eq_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hl   <= '0;
      fld  <= 1'b0;
      vout <= '0;
    end else begin
      vout.vsync <= (pos >= vs) && (pos < ve);
      vout.veq   <= cfg_eq_en && (pos >= es) && (pos < ee);
      vout.field <= fld;
      if (cfg_progressive) fld <= 1'b0;
      if (half_tick) begin
        if (hl >= cfg_field_len) begin
          hl <= '0;
          if (!cfg_progressive) fld <= ~fld;
        end else begin
          hl <= hl + VW'(1);
        end
      end
    end
  end

  AST_HL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !half_tick) |=> $stable(hl)) else $error("half-line moved"); // R5
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (rst)
    (en && half_tick && hl >= cfg_field_len && !cfg_progressive) |=> (fld != $past(fld)))
    else $error("field flip"); // R8
  AST_PROG_FIELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_progressive) |=> !fld) else $error("progressive field"); // R8
  AST_EQ_GATE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_eq_en) |=> !vout.veq) else $error("eq gate"); // R7
endmodule

// File: rtl/tvsync_timing_gen.sv
module tvsync_timing_gen
  import tvs_pkg::*;
#(
  parameter int HW = DEF_HW,
  parameter int VW = DEF_VW,
  parameter int SW = DEF_SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [HW-1:0] cfg_line_total,
  input  logic [HW-1:0] cfg_hsync_len,
  input  logic [HW-1:0] cfg_hblank_start,
  input  logic [HW-1:0] cfg_hblank_end,
  input  logic          cfg_burst_en,
  input  logic [HW-1:0] cfg_burst_start,
  input  logic [HW-1:0] cfg_burst_len,
  input  logic          cfg_progressive,
  input  logic [VW-1:0] cfg_field_len,
  input  logic [VW-1:0] cfg_vsync_len,
  input  logic [SW-1:0] cfg_vsync_start_f1,
  input  logic [SW-1:0] cfg_vsync_start_f2,
  input  logic          cfg_eq_en,
  input  logic [SW-1:0] cfg_eq_len,
  input  logic [SW-1:0] cfg_eq_start_f1,
  input  logic [SW-1:0] cfg_eq_start_f2,
  output logic          hsync,
  output logic          hblank,
  output logic          burst,
  output logic          vsync,
  output logic          veq,
  output logic          field_id
);
  h_out_t hout;
  v_out_t vout;
  logic   half_tick;

  tvs_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .en(en),
    .cfg_line_total(cfg_line_total), .cfg_hsync_len(cfg_hsync_len),
    .cfg_hblank_start(cfg_hblank_start), .cfg_hblank_end(cfg_hblank_end),
    .cfg_burst_en(cfg_burst_en), .cfg_burst_start(cfg_burst_start),
    .cfg_burst_len(cfg_burst_len), .half_tick(half_tick), .hout(hout)
  );

  tvs_vcount #(.VW(VW), .SW(SW)) u_v (
    .clk(clk), .rst(rst), .en(en), .half_tick(half_tick),
    .cfg_progressive(cfg_progressive), .cfg_field_len(cfg_field_len),
    .cfg_vsync_len(cfg_vsync_len), .cfg_vsync_start_f1(cfg_vsync_start_f1),
    .cfg_vsync_start_f2(cfg_vsync_start_f2), .cfg_eq_en(cfg_eq_en),
    .cfg_eq_len(cfg_eq_len), .cfg_eq_start_f1(cfg_eq_start_f1),
    .cfg_eq_start_f2(cfg_eq_start_f2), .vout(vout)
  );

  assign hsync    = hout.hsync;
  assign hblank   = hout.hblank;
  assign burst    = hout.burst;
  assign vsync    = vout.vsync;
  assign veq      = vout.veq;
  assign field_id = vout.field;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> !(hsync || hblank || burst || vsync || veq || field_id))
    else $error("outputs active while idle"); // R1
endmodule

// File: tb/test_tvsync_timing_gen.sv
module test_tvsync_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 13, VW = 11, SW = 7;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [HW-1:0] lt, hsl, hbs, hbe, bst, bln;
  logic burst_en, prog, eq_en;
  logic [VW-1:0] fl, vln;
  logic [SW-1:0] vs1, vs2, eln, es1, es2;
  logic hsync, hblank, burst, vsync, veq, field_id;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tvsync_timing_gen #(.HW(HW), .VW(VW), .SW(SW)) i_tvsync_timing_gen (
    .clk(clk), .rst(rst), .en(en),
    .cfg_line_total(lt), .cfg_hsync_len(hsl), .cfg_hblank_start(hbs),
    .cfg_hblank_end(hbe), .cfg_burst_en(burst_en), .cfg_burst_start(bst),
    .cfg_burst_len(bln), .cfg_progressive(prog), .cfg_field_len(fl),
    .cfg_vsync_len(vln), .cfg_vsync_start_f1(vs1), .cfg_vsync_start_f2(vs2),
    .cfg_eq_en(eq_en), .cfg_eq_len(eln), .cfg_eq_start_f1(es1),
    .cfg_eq_start_f2(es2),
    .hsync(hsync), .hblank(hblank), .burst(burst), .vsync(vsync),
    .veq(veq), .field_id(field_id)
  );

  // Behavioural reference: integer positions, advanced per the requirements.
  int m_px = 0, m_hl = 0, m_fld = 0;
  bit e_hs, e_hb, e_bu, e_vs, e_eq, e_fi;
  always @(posedge clk) begin
    int s, e, mid;
    if (rst || !en) begin
      m_px = 0; m_hl = 0; m_fld = 0;
      {e_hs, e_hb, e_bu, e_vs, e_eq, e_fi} = '0;
    end else begin
      e_hs = m_px < int'(hsl);
      e_hb = (m_px >= int'(hbs) + 1) || (m_px < int'(hbe) + 1);
      e_bu = burst_en && (m_px >= int'(bst) + 1) && (m_px < int'(bst) + 1 + int'(bln));
      s = (m_fld != 0) ? int'(vs2) : int'(vs1);
      e_vs = (m_hl >= s + 1) && (m_hl < s + 1 + int'(vln));
      e = (m_fld != 0) ? int'(es2) : int'(es1);
      e_eq = eq_en && (m_hl >= e + 1) && (m_hl < e + 1 + int'(eln));
      e_fi = m_fld != 0;
      mid = ((int'(lt) + 1) >> 1) - 1;
      if (prog) m_fld = 0;
      if (m_px == int'(lt) || m_px == mid) begin
        if (m_hl >= int'(fl)) begin
          m_hl = 0;
          if (!prog) m_fld = 1 - m_fld;
        end else m_hl = m_hl + 1;
      end
      m_px = (m_px >= int'(lt)) ? 0 : m_px + 1;
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(hsync,    e_hs, "R2 hsync");
      chk(hblank,   e_hb, "R3 hblank");
      chk(burst,    e_bu, "R4 burst");
      chk(vsync,    e_vs, "R5 R6 vsync half-line timing");
      chk(veq,      e_eq, "R7 equalization");
      chk(field_id, e_fi, "R8 field_id");
    end
  end

  // R9: spacing of field_id changes during the odd-length interlaced phase.
  bit r9_on = 1'b0;
  int r9_gap = -1, r9_seen = 0;
  bit last_fid = 1'b0;
  always @(negedge clk) begin
    if (r9_on) begin
      if (field_id !== last_fid) begin
        if (r9_gap >= 0) begin
          checks++; r9_seen++;
          if (r9_gap != 210) begin
            fails++;
            $display("FAIL R9 field spacing actual=%0d expected=210", r9_gap);
          end
        end
        r9_gap = 1;
      end else if (r9_gap >= 0) r9_gap++;
      last_fid = field_id;
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle_check(input string tag);
    en = 1'b0;
    run(3);
    @(negedge clk);
    checks++;
    if ({hsync, hblank, burst, vsync, veq, field_id} !== 6'b0) begin
      fails++;
      $display("FAIL %s idle outputs actual=%b expected=000000", tag,
               {hsync, hblank, burst, vsync, veq, field_id});
    end
    #2;
  endtask

  initial begin
    lt = 19; hsl = 3; hbs = 16; hbe = 6; burst_en = 1; bst = 4; bln = 4;
    prog = 0; fl = 20; vln = 3; vs1 = 1; vs2 = 2;
    eq_en = 1; eln = 2; es1 = 5; es2 = 6;
    run(4);
    @(negedge clk);
    checks++;
    if ({hsync, hblank, burst, vsync, veq, field_id} !== 6'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b expected=000000",
               {hsync, hblank, burst, vsync, veq, field_id});
    end
    #2;
    rst = 1'b0;
    cmp_on = 1'b1;
    run(2);
    // Interlaced, odd field length: 21 half-lines of 10 px -> 210 clocks
    en = 1'b1; r9_on = 1'b1;
    run(2000);
    r9_on = 1'b0;
    checks++;
    if (r9_seen < 3) begin
      fails++;
      $display("FAIL R9 field changes seen actual=%0d expected>=3", r9_seen);
    end
    idle_check("R1 after interlaced");
    // Progressive, burst gated off
    prog = 1; burst_en = 0; fl = 12;
    en = 1'b1;
    run(1500);
    idle_check("R1 after progressive");
    // Odd line total, equalization off, interlaced
    lt = 18; prog = 0; eq_en = 0; burst_en = 1; fl = 15; hbs = 14; hbe = 2;
    en = 1'b1;
    run(800);
    // Drop enable mid-line and restart
    en = 1'b0; run(1); en = 1'b1;
    run(700);
    // Two-pixel line with one-pixel sync
    lt = 1; hsl = 1; hbs = 0; hbe = 0; bst = 0; bln = 1; eq_en = 1; fl = 9;
    en = 1'b0; run(2); en = 1'b1;
    run(300);
    rst = 1'b1; run(1);
    @(negedge clk);
    cmp_on = 1'b0;
    checks++;
    if ({hsync, hblank, burst, vsync, veq, field_id} !== 6'b0) begin
      fails++;
      $display("FAIL R1 mid-run reset actual=%b expected=000000",
               {hsync, hblank, burst, vsync, veq, field_id});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule